// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running time of day in whole nanoseconds. A reference strobe marks every 8 ns period. On each strobe the count moves forward by a fixed whole step of 8 ns. A signed fractional trim is accumulated underneath the count, so the average rate can be pulled slightly faster or slower than nominal. When the fraction overflows, the step for that strobe becomes 9 ns. When it underflows, the step becomes 7 ns.

Software reaches the block through a small word-wide register port. It can program the trim word, run or halt the counter, load a new time and read the current time.

- **Reading:** the 40-bit count is read as two words. Reading the low word captures the upper bits into a snapshot, and a later read of the high word returns that snapshot. The two halves therefore always belong to the same instant.
- **Loading:** a new time is written low word first. Writing the high word then applies the whole value in one cycle.

A one-cycle pulse marks each rollover of the 40-bit count, so a downstream epoch extender can follow it.

Top module: `tod_clock`

## Requirements
- R1: After synchronous reset the count is 0, the trim word is 0, the wrap pulse is low, the read data is 0, and the control word reads 0x8000_0000 (halt bit 31 set).
- R2: While control bit 31 is 1, strobes do not change the count.
- R3: With a zero trim word and the counter running, each strobe adds exactly 8 to the count. Cycles without a strobe leave the count unchanged.
- R4: When trim bit 31 is 0, the magnitude in bits 30:0 is added to a 32-bit fraction on every strobe. A carry out makes that strobe's step 9. With magnitude 0x4000_0000, four strobes from a cleared fraction advance the count by 33.
- R5: When trim bit 31 is 1, the magnitude is subtracted from the fraction on every strobe. A borrow makes that strobe's step 7. With magnitude 0x4000_0000, four strobes from a cleared fraction advance the count by 31.
- R6: A read of address 0 returns count bits 31:0 and captures count bits 39:32. A later read of address 1 returns the captured bits in 7:0 with zeros above, even if the count has since changed.
- R7: A write to address 0 only stages the low word and leaves the count unchanged. A write to address 1 loads {data[7:0], staged low word} into the count in one step and clears the fraction.
- R8: The wrap output is high for exactly the one cycle after a strobe that carries the count past 2^40-1.
- R9: The trim word at address 2 reads back as written. Control bit 31 at address 3 reads back as written. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference strobe, one per 8 ns period |
| bus_addr | input | 2 | Register address: 0 time low, 1 time high, 2 trim, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| time_ns | output | 40 | Current nanosecond count |
| wrap | output | 1 | One-cycle rollover pulse |

## Verification
The bench builds the block with its defaults: a 40-bit count, a 32-bit word and an 8 ns step. Loading a time four nanoseconds below the top of the range brings the rollover pulse within a single strobe. A quarter-nanosecond trim magnitude produces a carry or borrow every fourth strobe, so both the 9 ns and the 7 ns steps appear in short runs. Loading a new time between a low-word read and a high-word read shows that the snapshot is held.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        REG_TIME_LO = 2'd0,
        REG_TIME_HI = 2'd1,
        REG_TRIM    = 2'd2,
        REG_CTRL    = 2'd3
    } tod_reg_e;

    typedef struct packed {
        logic              neg;
        logic [WORD_W-2:0] mag;
    } trim_t;

    typedef struct packed {
        logic carry;
        logic borrow;
    } trim_evt_t;

    function automatic trim_t unpack_trim(input logic [WORD_W-1:0] w);
        trim_t t;
        t.neg = w[WORD_W-1];
        t.mag = w[WORD_W-2:0];
        return t;
    endfunction

endpackage

// File: rtl/tod_frac_acc.sv
module tod_frac_acc
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  logic      clr,
    input  trim_t     trim,
    output trim_evt_t evt
);
    localparam int FRAC_W = WORD_W;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        evt = '0;
        if (trim.neg) begin
            sum        = {1'b0, acc_q} - {2'b00, trim.mag};
            evt.borrow = sum[FRAC_W];
        end else begin
            sum       = {1'b0, acc_q} + {2'b00, trim.mag};
            evt.carry = sum[FRAC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (adv)
            acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter
    import tod_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  trim_evt_t       evt,
    input  logic            load,
    input  logic [NS_W-1:0] load_val,
    output logic [NS_W-1:0] ns_q,
    output logic            wrap_q
);
    logic [NS_W:0] step;
    logic [NS_W:0] nxt;

    always_comb begin
        step = (NS_W+1)'(STEP_NS) + (NS_W+1)'(evt.carry) - (NS_W+1)'(evt.borrow);
        nxt  = {1'b0, ns_q} + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q   <= '0;
            wrap_q <= 1'b0;
        end else if (load) begin
            ns_q   <= load_val;
            wrap_q <= 1'b0;
        end else if (adv) begin
            ns_q   <= nxt[NS_W-1:0];
            wrap_q <= nxt[NS_W];
        end else begin
            wrap_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tod_reg_if.sv
module tod_reg_if
    import tod_pkg::*;
#(
    parameter int NS_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd,
    output logic [WORD_W-1:0] rdata,
    input  logic [NS_W-1:0]   ns,
    output logic              halt,
    output trim_t             trim,
    output logic              load,
    output logic [NS_W-1:0]   load_val
);
    localparam int HI_W = NS_W - WORD_W;

    logic [WORD_W-1:0] trim_q;
    logic [WORD_W-1:0] stage_lo_q;
    logic [HI_W-1:0]   snap_hi_q;
    logic              halt_q;

    assign halt     = halt_q;
    assign trim     = unpack_trim(trim_q);
    assign load     = wr && (tod_reg_e'(addr) == REG_TIME_HI);
    assign load_val = {wdata[HI_W-1:0], stage_lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q     <= '0;
            stage_lo_q <= '0;
            halt_q     <= 1'b1;
        end else if (wr) begin
            case (tod_reg_e'(addr))
                REG_TIME_LO: stage_lo_q <= wdata;
                REG_TRIM:    trim_q     <= wdata;
                REG_CTRL:    halt_q     <= wdata[WORD_W-1];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            snap_hi_q <= '0;
        end else if (rd) begin
            case (tod_reg_e'(addr))
                REG_TIME_LO: begin
                    rdata     <= ns[WORD_W-1:0];
                    snap_hi_q <= ns[NS_W-1:WORD_W];
                end
                REG_TIME_HI: rdata <= {{(WORD_W-HI_W){1'b0}}, snap_hi_q};
                REG_TRIM:    rdata <= trim_q;
                default:     rdata <= {halt_q, {(WORD_W-1){1'b0}}};
            endcase
        end
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int NS_W    = 40,
    parameter int STEP_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NS_W-1:0]   time_ns,
    output logic              wrap
);
    logic            halt_w;
    trim_t           trim_w;
    logic            load_w;
    logic [NS_W-1:0] load_val_w;
    logic            adv_w;
    trim_evt_t       evt_w;

    assign adv_w = tick && !halt_w && !load_w;

    tod_reg_if #(.NS_W(NS_W)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .rd(bus_rd), .rdata(bus_rdata), .ns(time_ns), .halt(halt_w),
        .trim(trim_w), .load(load_w), .load_val(load_val_w)
    );

    tod_frac_acc u_frac (
        .clk(clk), .rst(rst), .adv(adv_w), .clr(load_w), .trim(trim_w), .evt(evt_w)
    );

    tod_ns_counter #(.NS_W(NS_W), .STEP_NS(STEP_NS)) u_cnt (
        .clk(clk), .rst(rst), .adv(adv_w), .evt(evt_w), .load(load_w),
        .load_val(load_val_w), .ns_q(time_ns), .wrap_q(wrap)
    );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int NS_W = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [NS_W-1:0]   time_ns,
    input logic              wrap,
    input logic              halt_w,
    input logic              trim_neg
);
    localparam int HI_W = NS_W - WORD_W;

    logic ld;
    assign ld = bus_wr && (tod_reg_e'(bus_addr) == REG_TIME_HI);

    // R2
    p_halt_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        (halt_w && !ld) |=> $stable(time_ns));

    // R3
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld) |=> $stable(time_ns));

    // R4
    p_step_range_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt_w && !ld) |=>
        ((time_ns - $past(time_ns)) == 7 || (time_ns - $past(time_ns)) == 8 ||
         (time_ns - $past(time_ns)) == 9));

    // R5
    p_neg_never_fast_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt_w && !ld && trim_neg) |=> ((time_ns - $past(time_ns)) != 9));

    // R6
    p_hi_read_narrow_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && tod_reg_e'(bus_addr) == REG_TIME_HI) |=> (bus_rdata[WORD_W-1:HI_W] == '0));

    // R8
    p_wrap_single_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);

    // R8
    p_wrap_low_count_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (time_ns < 9));
endmodule

bind tod_clock tod_clock_chk #(.NS_W(NS_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .time_ns(time_ns), .wrap(wrap),
    .halt_w(halt_w), .trim_neg(trim_w.neg)
);

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
    localparam int CLK_PERIOD = 10;
    localparam int NS_W = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [NS_W-1:0] time_ns;
    logic        wrap;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_clock dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .time_ns(time_ns), .wrap(wrap)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_time(input logic [7:0] hi, input logic [31:0] lo);
        bus_write(2'd0, lo);
        bus_write(2'd1, {24'd0, hi});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 count", time_ns, 0);
        check("R1 wrap", wrap, 0);
        check("R1 rdata", bus_rdata, 0);
        bus_read(2'd3, d);
        check("R1 control", d, 32'h8000_0000);
        bus_read(2'd2, d);
        check("R1 trim", d, 0);
    endtask

    task automatic t_halted;
        run_ticks(5);
        check("R2 halted count", time_ns, 0);
        bus_write(2'd3, 32'h0);
    endtask

    task automatic t_nominal;
        logic [31:0] d;
        bus_read(2'd3, d);
        check("R9 control readback", d, 0);
        run_ticks(10);
        check("R3 ten strobes", time_ns, 80);
        repeat (3) @(negedge clk);
        check("R3 idle hold", time_ns, 80);
    endtask

    task automatic t_fast;
        bus_write(2'd2, 32'h4000_0000);
        bus_write(2'd0, 32'd100);
        check("R7 low write only stages", time_ns, 80);
        bus_write(2'd1, 32'd0);
        check("R7 load applied", time_ns, 100);
        run_ticks(4);
        check("R4 four strobes", time_ns, 133);
        run_ticks(4);
        check("R4 eight strobes", time_ns, 166);
    endtask

    task automatic t_slow;
        logic [31:0] d;
        bus_write(2'd2, 32'hC000_0000);
        load_time(8'h00, 32'd1000);
        run_ticks(4);
        check("R5 four strobes", time_ns, 1031);
        run_ticks(4);
        check("R5 eight strobes", time_ns, 1062);
        bus_read(2'd2, d);
        check("R9 trim readback", d, 32'hC000_0000);
        bus_write(2'd2, 32'h0);
    endtask

    task automatic t_snapshot;
        logic [31:0] d;
        load_time(8'h12, 32'h3456_7890);
        check("R7 full load", time_ns, 40'h12_3456_7890);
        bus_read(2'd0, d);
        check("R6 low word", d, 32'h3456_7890);
        load_time(8'h55, 32'h0);
        bus_read(2'd1, d);
        check("R6 held high word", d, 32'h12);
        bus_read(2'd0, d);
        check("R6 new low word", d, 0);
        bus_read(2'd1, d);
        check("R6 new high word", d, 32'h55);
    endtask

    task automatic t_wrap;
        load_time(8'hFF, 32'hFFFF_FFFC);
        check("R8 no pulse before", wrap, 0);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R8 count after rollover", time_ns, 4);
        check("R8 pulse high", wrap, 1);
        @(negedge clk);
        check("R8 pulse one cycle", wrap, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_halted();
        t_nominal();
        t_fast();
        t_slow();
        t_snapshot();
        t_wrap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule